// File: doc/BRIEF.md
# Nibble-coded multicycle processor core

This block is a small multicycle processor that runs 16-bit instructions kept in a byte-wide memory. Every instruction word is four hex nibbles. The top nibble picks the operation, and the three lower nibbles are operand fields whose meaning depends on that operation. The core holds a program counter and an instruction register. It steps through fetch, decode and execute using sixteen 8-bit general registers and a small ALU that performs OR, AND and rotate-right.

The core connects to one synchronous single-port memory. The memory registers its read data, so data appears one cycle after the address is presented. Writes take effect on the clock edge at which the write enable is high. Reset clears the core and starts execution at address 00h. A halt instruction stops the core and raises a flag that the surrounding logic can watch.

Top module: `hexcpu_core`

## Requirements
- R1: While reset is low, and on its release, the program counter and all sixteen registers are zero, halted_o and mem_we_o are low, and the first address driven is 00h.
- R2: A fetch reads the high instruction byte from PC and the low byte from PC+1, and then adds 2 to PC. Every instruction except a memory load completes in 4 clock cycles. A memory load completes in 5.
- R3: Op-code 1 (1RXY) loads register R from memory address XY.
- R4: Op-code 2 (2RXY) loads the constant byte XY into register R.
- R5: Op-code 3 (3RXY) writes register R to memory address XY during a single cycle with mem_we_o high. No other address is written.
- R6: Op-code 7 (7RST) sets R to S OR T. Op-code 8 (8RST) sets R to S AND T.
- R7: Op-code A (AR0X) rotates register R right by X modulo 8. Bits leaving bit 0 re-enter at bit 7. For example, 65h rotated by 1 gives B2h.
- R8: Op-code B (BRXY) sets PC to XY when register R equals register 0. Otherwise execution continues at the next instruction.
- R9: Op-code C halts the core. halted_o then stays high and no memory write or further fetch happens until the next reset.
- R10: Op-codes 0, 4, 5, 6, 9, D, E and F change no register or memory location, and execution continues at the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 8 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 8 | Memory read data, registered one cycle after the address |
| halted_o | output | 1 | High after a halt until reset |

## Verification
Register contents can only be seen through stores. A corrupted register or ALU result therefore reaches the ports when the next store writes a wrong byte, which takes at least four cycles after the faulty execute. A wrong PC or instruction register shows up as a wrong fetch address within a cycle. It also shows up as a halt at the wrong cycle count or one that never comes, so the checks measure both stored bytes and the exact cycle at which halted_o rises.

// File: rtl/hexcpu_pkg.sv
package hexcpu_pkg;
  localparam logic [3:0] OP_LOAD  = 4'h1;
  localparam logic [3:0] OP_LDI   = 4'h2;
  localparam logic [3:0] OP_STORE = 4'h3;
  localparam logic [3:0] OP_OR    = 4'h7;
  localparam logic [3:0] OP_AND   = 4'h8;
  localparam logic [3:0] OP_ROR   = 4'hA;
  localparam logic [3:0] OP_JEQ   = 4'hB;
  localparam logic [3:0] OP_HALT  = 4'hC;

  typedef enum logic [2:0] {
    ST_FETCH_HI, ST_FETCH_LO, ST_LATCH, ST_EXEC, ST_WBACK, ST_HALT
  } state_e;

  typedef enum logic [1:0] {ALU_OR, ALU_AND, ALU_ROR} alu_op_e;

  function automatic logic op_known(input logic [3:0] op);
    case (op)
      OP_LOAD, OP_LDI, OP_STORE, OP_OR, OP_AND, OP_ROR, OP_JEQ, OP_HALT: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/hexcpu_alu.sv
module hexcpu_alu
  import hexcpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e             op_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic [DATA_W/2-1:0] amt_i,
  output logic [DATA_W-1:0]   res_o
);
  localparam int SH_W = $clog2(DATA_W);

  logic [2*DATA_W-1:0] dbl;
  logic [SH_W-1:0]     sh;

  assign sh  = amt_i[SH_W-1:0];      // amount taken modulo DATA_W
  assign dbl = {a_i, a_i} >> sh;

  always_comb begin
    case (op_i)
      ALU_OR:  res_o = a_i | b_i;
      ALU_AND: res_o = a_i & b_i;
      default: res_o = dbl[DATA_W-1:0];
    endcase
  end

  always_comb begin
    if (op_i == ALU_ROR) begin
      assert_ror_keeps_ones_R7: assert ($countones(res_o) == $countones(a_i));
    end
    if (op_i == ALU_AND) begin
      assert_and_subset_R6: assert ((res_o & ~a_i) == '0);
    end
  end
endmodule

// File: rtl/hexcpu_regfile.sv
module hexcpu_regfile #(
  parameter int DATA_W = 8,
  localparam int SEL_W = DATA_W / 2,
  localparam int NREG  = 2 ** SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SEL_W-1:0]  ra_i,
  input  logic [SEL_W-1:0]  rb_i,
  input  logic [SEL_W-1:0]  rc_i,
  output logic [DATA_W-1:0] ra_o,
  output logic [DATA_W-1:0] rb_o,
  output logic [DATA_W-1:0] rc_o,
  output logic [DATA_W-1:0] r0_o
);
  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we_i) begin
      regs[waddr_i] <= wdata_i;
    end
  end

  assign ra_o = regs[ra_i];
  assign rb_o = regs[rb_i];
  assign rc_o = regs[rc_i];
  assign r0_o = regs[0];
endmodule

// File: rtl/hexcpu_ctrl.sv
module hexcpu_ctrl
  import hexcpu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int NIB_W  = DATA_W / 2,
  localparam int INSN_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              halted_o,
  output logic              rf_we_o,
  output logic [NIB_W-1:0]  rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic [NIB_W-1:0]  rf_ra_o,
  output logic [NIB_W-1:0]  rf_rb_o,
  output logic [NIB_W-1:0]  rf_rc_o,
  input  logic [DATA_W-1:0] rf_a_i,
  input  logic [DATA_W-1:0] rf_b_i,
  input  logic [DATA_W-1:0] rf_c_i,
  input  logic [DATA_W-1:0] rf_r0_i,
  output alu_op_e           alu_op_o,
  output logic [DATA_W-1:0] alu_a_o,
  output logic [DATA_W-1:0] alu_b_o,
  output logic [NIB_W-1:0]  alu_amt_o,
  input  logic [DATA_W-1:0] alu_res_i
);
  state_e              state;
  logic [DATA_W-1:0]   pc;
  logic [INSN_W-1:0]   ir;
  logic [NIB_W-1:0]    op, f_r, f_s, f_t;
  logic [DATA_W-1:0]   imm;
  logic                take_jump;

  assign op  = ir[INSN_W-1 -: NIB_W];
  assign f_r = ir[3*NIB_W-1 -: NIB_W];
  assign f_s = ir[2*NIB_W-1 -: NIB_W];
  assign f_t = ir[NIB_W-1:0];
  assign imm = ir[DATA_W-1:0];
  assign take_jump = (op == OP_JEQ) && (rf_a_i == rf_r0_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_FETCH_HI;
      pc    <= '0;
      ir    <= '0;
    end else begin
      case (state)
        ST_FETCH_HI: state <= ST_FETCH_LO;
        ST_FETCH_LO: begin
          ir[INSN_W-1 -: DATA_W] <= mem_rdata_i;
          state <= ST_LATCH;
        end
        ST_LATCH: begin
          ir[DATA_W-1:0] <= mem_rdata_i;
          pc    <= pc + DATA_W'(2);
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (take_jump) pc <= imm;
          case (op)
            OP_LOAD: state <= ST_WBACK;
            OP_HALT: state <= ST_HALT;
            default: state <= ST_FETCH_HI;
          endcase
        end
        ST_WBACK: state <= ST_FETCH_HI;
        default:  state <= ST_HALT;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_FETCH_LO: mem_addr_o = pc + DATA_W'(1);
      ST_EXEC:     mem_addr_o = (op == OP_LOAD || op == OP_STORE) ? imm : pc;
      ST_WBACK:    mem_addr_o = imm;
      default:     mem_addr_o = pc;
    endcase
  end

  assign mem_we_o    = (state == ST_EXEC) && (op == OP_STORE);
  assign mem_wdata_o = rf_a_i;
  assign halted_o    = (state == ST_HALT);

  assign rf_ra_o    = f_r;
  assign rf_rb_o    = f_s;
  assign rf_rc_o    = f_t;
  assign rf_waddr_o = f_r;
  assign rf_we_o    = (state == ST_WBACK) ||
                      ((state == ST_EXEC) &&
                       (op == OP_LDI || op == OP_OR || op == OP_AND || op == OP_ROR));

  always_comb begin
    if (state == ST_WBACK)  rf_wdata_o = mem_rdata_i;
    else if (op == OP_LDI)  rf_wdata_o = imm;
    else                    rf_wdata_o = alu_res_i;
  end

  always_comb begin
    case (op)
      OP_AND:  alu_op_o = ALU_AND;
      OP_ROR:  alu_op_o = ALU_ROR;
      default: alu_op_o = ALU_OR;
    endcase
  end

  assign alu_a_o   = (op == OP_ROR) ? rf_a_i : rf_b_i;
  assign alu_b_o   = rf_c_i;
  assign alu_amt_o = f_t;

  assert_fetch_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FETCH_LO) |-> (mem_addr_o == $past(mem_addr_o) + DATA_W'(1)));
  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_LATCH) |=> (pc == $past(pc) + DATA_W'(2)));
  assert_single_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  assert_jump_target_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXEC && op == OP_JEQ && rf_a_i == rf_r0_i) |=> (pc == $past(imm)));
  assert_halt_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(mem_addr_o)));
  assert_halt_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_we_o);
  assert_unknown_is_nop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXEC && !op_known(op)) |-> (!mem_we_o && !rf_we_o));
endmodule

// File: rtl/hexcpu_core.sv
module hexcpu_core
  import hexcpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              halted_o
);
  localparam int NIB_W = DATA_W / 2;

  logic              rf_we;
  logic [NIB_W-1:0]  rf_waddr, rf_ra, rf_rb, rf_rc, alu_amt;
  logic [DATA_W-1:0] rf_wdata, rf_a, rf_b, rf_c, rf_r0;
  logic [DATA_W-1:0] alu_a, alu_b, alu_res;
  alu_op_e           alu_op;

  hexcpu_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni,
    .mem_addr_o, .mem_wdata_o, .mem_we_o, .mem_rdata_i, .halted_o,
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .rf_ra_o(rf_ra), .rf_rb_o(rf_rb), .rf_rc_o(rf_rc),
    .rf_a_i(rf_a), .rf_b_i(rf_b), .rf_c_i(rf_c), .rf_r0_i(rf_r0),
    .alu_op_o(alu_op), .alu_a_o(alu_a), .alu_b_o(alu_b),
    .alu_amt_o(alu_amt), .alu_res_i(alu_res)
  );

  hexcpu_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk_i, .rst_ni,
    .we_i(rf_we), .waddr_i(rf_waddr), .wdata_i(rf_wdata),
    .ra_i(rf_ra), .rb_i(rf_rb), .rc_i(rf_rc),
    .ra_o(rf_a), .rb_o(rf_b), .rc_o(rf_c), .r0_o(rf_r0)
  );

  hexcpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i(alu_op), .a_i(alu_a), .b_i(alu_b), .amt_i(alu_amt), .res_o(alu_res)
  );
endmodule

// File: tb/sim_hexcpu_core.sv
module sim_hexcpu_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rd;
  logic       mem_we, halted;
  logic       ld_we = 1'b0;
  logic [7:0] ld_addr = '0, ld_data = '0;
  logic [7:0] mem [256];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (ld_we) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rd <= mem[mem_addr];
  end

  hexcpu_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_rdata_i(mem_rd), .halted_o(halted)
  );

  // opcode, a, b, rotate amount, expected
  localparam logic [31:0] VEC [9] = '{
    {4'h7, 8'h0F, 8'hA0, 4'h0, 8'hAF},
    {4'h8, 8'h3C, 8'hF0, 4'h0, 8'h30},
    {4'h7, 8'h00, 8'h00, 4'h0, 8'h00},
    {4'h8, 8'hFF, 8'h5A, 4'h0, 8'h5A},
    {4'hA, 8'h65, 8'h00, 4'h1, 8'hB2},
    {4'hA, 8'h65, 8'h00, 4'h2, 8'h59},
    {4'hA, 8'h81, 8'h00, 4'h8, 8'h81},
    {4'hA, 8'h01, 8'h00, 4'h7, 8'h02},
    {4'hA, 8'h80, 8'h00, 4'hF, 8'h01}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    ld_addr = a; ld_data = d; ld_we = 1'b1;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] w);
    poke(a, w[15:8]);
    poke(a + 8'd1, w[7:0]);
  endtask

  task automatic clear_mem();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) poke(8'(i), 8'h00);
  endtask

  task automatic run(output int cyc);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 halted in reset", int'(halted), 0);
    check("R1 we in reset", int'(mem_we), 0);

    // ALU vector table: R4 immediates, R6 OR/AND, R7 rotate
    foreach (VEC[k]) begin
      logic [3:0] vop; logic [7:0] va, vb, vexp; logic [3:0] vamt;
      {vop, va, vb, vamt, vexp} = VEC[k];
      clear_mem();
      put(8'h00, {8'h21, va});
      put(8'h02, {8'h22, vb});
      if (vop == 4'hA) begin
        put(8'h04, {4'hA, 4'h1, 4'h0, vamt});
        put(8'h06, 16'h31F0);
      end else begin
        put(8'h04, {vop, 12'h312});
        put(8'h06, 16'h33F0);
      end
      put(8'h08, 16'hC000);
      run(cyc);
      if (vop == 4'hA) check("R7 rotate result", int'(mem[8'hF0]), int'(vexp));
      else             check("R6 logic result", int'(mem[8'hF0]), int'(vexp));
    end

    // R1: registers cleared by reset, first address 00h
    clear_mem();
    put(8'h00, 16'h2799);
    put(8'h02, 16'hC000);
    run(cyc);
    clear_mem();
    poke(8'h80, 8'h55);
    put(8'h00, 16'h3780);
    put(8'h02, 16'hC000);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 first fetch address", int'(mem_addr), 0);
    cyc = 0;
    while (!halted && cyc < 2000) begin @(negedge clk); cyc++; end
    check("R1 register cleared", int'(mem[8'h80]), 0);

    // R2/R9: halt alone takes 4 cycles
    clear_mem();
    put(8'h00, 16'hC000);
    run(cyc);
    check("R2 cycles halt only", cyc, 4);

    // R2/R4: immediate then halt = 8 cycles
    clear_mem();
    put(8'h00, 16'h2105);
    put(8'h02, 16'hC000);
    run(cyc);
    check("R2 cycles ldi", cyc, 8);

    // R3: memory load, 5 cycles, high register R15
    clear_mem();
    poke(8'h20, 8'hC3);
    put(8'h00, 16'h1F20);
    put(8'h02, 16'hC000);
    run(cyc);
    check("R2 cycles load", cyc, 9);
    clear_mem();
    poke(8'h20, 8'hC3);
    poke(8'hF2, 8'hEE);
    put(8'h00, 16'h1F20);
    put(8'h02, 16'h3FF1);
    put(8'h04, 16'hC000);
    run(cyc);
    check("R3 loaded value", int'(mem[8'hF1]), 8'hC3);
    check("R5 neighbour untouched", int'(mem[8'hF2]), 8'hEE);
    check("R4 source intact", int'(mem[8'h20]), 8'hC3);

    // R8: jump taken and not taken
    for (int t = 0; t < 2; t++) begin
      clear_mem();
      put(8'h00, 16'h2105);
      put(8'h02, (t == 0) ? 16'h2005 : 16'h2006);
      put(8'h04, 16'hB110);
      put(8'h06, 16'h2277);
      put(8'h08, 16'h32F0);
      put(8'h0A, 16'hC000);
      put(8'h10, 16'h2233);
      put(8'h12, 16'h32F0);
      put(8'h14, 16'hC000);
      run(cyc);
      if (t == 0) check("R8 jump taken", int'(mem[8'hF0]), 8'h33);
      else        check("R8 jump not taken", int'(mem[8'hF0]), 8'h77);
    end

    // R10: unimplemented opcodes are no-ops
    clear_mem();
    poke(8'hF1, 8'hAB);
    put(8'h00, 16'h2155);
    put(8'h02, 16'h4123);
    put(8'h04, 16'h9FFF);
    put(8'h06, 16'hF1F0);
    put(8'h08, 16'h31F0);
    put(8'h0A, 16'hC000);
    run(cyc);
    check("R10 register kept", int'(mem[8'hF0]), 8'h55);
    check("R10 memory kept", int'(mem[8'hF1]), 8'hAB);
    check("R10 sequencing cycles", cyc, 24);

    // R9: halt is sticky, nothing after it runs
    clear_mem();
    put(8'h00, 16'h2166);
    put(8'h02, 16'hC000);
    put(8'h04, 16'h31F0);
    run(cyc);
    begin
      int bad = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!halted || mem_we) bad++;
      end
      check("R9 halted and quiet", bad, 0);
    end
    check("R9 no store after halt", int'(mem[8'hF0]), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule